// File: doc/BRIEF.md
# Mode-Selectable Fixed-Duty Pulse Generator

This block turns a slow reference clock into a periodic timing waveform. The period has two possible lengths, and a single select input picks between them at run time. The short period is 10 reference cycles and the long one is 20. In both cases the waveform is high for the first fifth of the period and low for the rest, so the high fraction stays at 20% whichever length is in use. With a 1 kHz reference, one cycle is 1 ms, which gives 10 ms and 20 ms periods.

The select input may come from a clock domain unrelated to the reference. It is therefore resynchronised before use. It is also only acted on when one period ends and the next begins. A change of select never shortens or lengthens the period already in progress. The output comes straight from a flip-flop, so it carries no combinational glitches.

Internally, a base counter walks through the ten positions of a period. A prescaler lets that counter advance every cycle in the short mode and every second cycle in the long mode, which doubles both the high and the low phase exactly.

Top module: `pulse_mode_gen`

## Requirements
- R1: With the select latched at 0 for a period, that period lasts 10 cycles: `pulse_o` is 1 for its first 2 cycles and 0 for the following 8.
- R2: With the select latched at 1 for a period, that period lasts 20 cycles: `pulse_o` is 1 for its first 4 cycles and 0 for the following 16.
- R3: While `rst_i` is 1 at a rising clock edge, `pulse_o` is 0 in the cycle after that edge, including when reset arrives in the middle of a period.
- R4: On the first clock edge with `rst_i` at 0 after a reset, a new period begins, so `pulse_o` is 1 in the cycle right after that edge.
- R5: The select is sampled only at a period boundary. A change made in the middle of a period leaves that period unchanged. The new length applies from the next period, provided the change is made at least three cycles before the boundary.
- R6: The select passes through a two-stage synchroniser that reset clears to 0. The first period after reset is therefore always the 10-cycle period, whatever `mode_sel_i` holds.
- R7: If `mode_sel_i` changes in mid-period and then returns to its earlier value before the boundary, the next period has the length given by that earlier value.
- R8: Periods follow one another back to back. The first high cycle of a period comes directly after the last low cycle of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (1 kHz; one cycle is 1 ms) |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_sel_i | input | 1 | Period select: 0 gives 10 cycles, 1 gives 20 cycles; may be asynchronous |
| pulse_o | output | 1 | Registered waveform, high for 20% of each period |

## Verification
The bench measures the length of every high run and every low run on the output and compares each against the queue of expected periods. Some periods follow a mid-period change of select. A design that applied the select at once would give a truncated or mixed-length period at that point. Other periods follow a short wiggle of the select that returns to its old value. A design that sampled the select mid-period would switch length there by mistake. The bench drives the select to 1 throughout reset, which exposes a synchroniser that is not cleared by reset, because such a design would make the first period 20 cycles long. It also asserts reset during a high phase, which catches an output that stays high or a first period that starts late.

// File: rtl/pgen_pkg.sv
`timescale 1ns/1ps
package pgen_pkg;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } mode_e;

    // Number of reference cycles each base-counter step lasts in a mode
    function automatic int unsigned step_cycles(mode_e m, int unsigned long_mult);
        return (m == MODE_LONG) ? long_mult : 32'd1;
    endfunction

    function automatic mode_e mode_of(logic sel);
        return sel ? MODE_LONG : MODE_SHORT;
    endfunction

endpackage

// File: rtl/pgen_sync.sv
`timescale 1ns/1ps
module pgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgen_phase_ctr.sv
`timescale 1ns/1ps
module pgen_phase_ctr
    import pgen_pkg::*;
#(
    parameter int BASE_PERIOD = 10,
    parameter int LONG_MULT   = 2,
    localparam int CNT_W = (BASE_PERIOD > 1) ? $clog2(BASE_PERIOD) : 1,
    localparam int SUB_W = (LONG_MULT > 1) ? $clog2(LONG_MULT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    output logic [CNT_W-1:0] nxt_base_o,
    output mode_e            mode_o
);
    typedef struct packed {
        logic             run;
        mode_e            mode;
        logic [CNT_W-1:0] base;
        logic [SUB_W-1:0] sub;
    } phase_t;

    phase_t cur_q, nxt_d;
    logic   last_sub;
    logic   boundary;

    assign last_sub = (cur_q.sub == SUB_W'(step_cycles(cur_q.mode, LONG_MULT) - 1));
    assign boundary = !cur_q.run ||
                      (last_sub && (cur_q.base == CNT_W'(BASE_PERIOD - 1)));

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.run = 1'b1;
        if (boundary) begin
            nxt_d.mode = mode_of(sel_i);
            nxt_d.base = '0;
            nxt_d.sub  = '0;
        end else if (last_sub) begin
            nxt_d.sub  = '0;
            nxt_d.base = cur_q.base + 1'b1;
        end else begin
            nxt_d.sub  = cur_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{run: 1'b0, mode: MODE_SHORT, base: '0, sub: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign nxt_base_o = nxt_d.base;
    assign mode_o     = cur_q.mode;

    // mode only moves when a period closes
    AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(cur_q.mode)); // R5
endmodule

// File: rtl/pgen_out_stage.sv
`timescale 1ns/1ps
module pgen_out_stage #(
    parameter int CNT_W     = 4,
    parameter int BASE_HIGH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] nxt_base_i,
    output logic             pulse_o
);
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= (nxt_base_i < CNT_W'(BASE_HIGH));
    end

    assign pulse_o = pulse_q;

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !pulse_o); // R3

    AST_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |=> pulse_o); // R1
endmodule

// File: rtl/pulse_mode_gen.sv
`timescale 1ns/1ps
module pulse_mode_gen
    import pgen_pkg::*;
#(
    parameter int BASE_PERIOD = 10,
    parameter int BASE_HIGH   = 2,
    parameter int LONG_MULT   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W  = (BASE_PERIOD > 1) ? $clog2(BASE_PERIOD) : 1,
    localparam int MAX_HI = BASE_HIGH * LONG_MULT,
    localparam int HRUN_W = $clog2(MAX_HI + 2)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mode_sel_i,
    output logic pulse_o
);
    logic             sel_sync;
    logic [CNT_W-1:0] nxt_base;
    mode_e            cur_mode;

    pgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_i),
        .rst (rst_i),
        .d_i (mode_sel_i),
        .q_o (sel_sync)
    );

    pgen_phase_ctr #(.BASE_PERIOD(BASE_PERIOD), .LONG_MULT(LONG_MULT)) u_phase (
        .clk        (clk_i),
        .rst        (rst_i),
        .sel_i      (sel_sync),
        .nxt_base_o (nxt_base),
        .mode_o     (cur_mode)
    );

    pgen_out_stage #(.CNT_W(CNT_W), .BASE_HIGH(BASE_HIGH)) u_out (
        .clk        (clk_i),
        .rst        (rst_i),
        .nxt_base_i (nxt_base),
        .pulse_o    (pulse_o)
    );

    // Length of the current high run, kept for the checks below
    logic [HRUN_W-1:0] hi_run_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)        hi_run_q <= '0;
        else if (pulse_o) hi_run_q <= hi_run_q + 1'b1;
        else              hi_run_q <= '0;
    end

    AST_FIRST_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |=> pulse_o); // R4

    AST_HIGH_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> (32'(hi_run_q) < BASE_HIGH * int'(step_cycles(cur_mode, LONG_MULT)))); // R2
endmodule

// File: tb/pulse_mode_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_mode_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SH_HI = 2, SH_LO = 8, LG_HI = 4, LG_LO = 16;

    logic clk = 1'b0;
    logic rst, mode_sel, pulse;
    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_mode_gen dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .mode_sel_i (mode_sel),
        .pulse_o    (pulse)
    );

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push_exp(input bit m, input string tag);
        exp_t e;
        e.hi  = m ? LG_HI : SH_HI;
        e.lo  = m ? LG_LO : SH_LO;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: measure each high run and low run, pop and compare per period
    int mon_hi = 0, mon_lo = 0;
    bit mon_prev = 0, mon_seen = 0;
    always @(negedge clk) begin
        if (!mon_en) begin
            mon_prev = 0; mon_seen = 0; mon_hi = 0; mon_lo = 0;
        end else begin
            if (pulse) begin
                if (!mon_prev) begin
                    if (mon_seen) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R8 unexpected period", 1, 0);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            chk(mon_hi == e.hi, {e.tag, " high"}, mon_hi, e.hi);
                            chk(mon_lo == e.lo, {e.tag, " low"}, mon_lo, e.lo);
                        end
                    end
                    mon_seen = 1; mon_hi = 1; mon_lo = 0;
                end else begin
                    mon_hi++;
                end
            end else if (mon_seen) begin
                mon_lo++;
            end
            mon_prev = pulse;
        end
    end

    // Driver: at negedge in cycle 0 of period 0 on entry
    task automatic run_seq(input int n, input bit modes[16], input bit wig[16]);
        push_exp(1'b0, "R6 first period short");
        for (int i = 1; i < n; i++) begin
            string tag;
            repeat (3) @(negedge clk);
            if (wig[i]) begin
                mode_sel = !modes[i];
                repeat (2) @(negedge clk);
            end
            mode_sel = modes[i];
            if (wig[i])                    tag = "R7 wiggle ignored";
            else if (modes[i] != modes[i-1]) tag = "R5 switch at boundary";
            else                           tag = modes[i] ? "R2 long" : "R1 short";
            push_exp(modes[i], tag);
            @(posedge pulse);
            @(negedge clk);
        end
        for (int k = 0; k < 100 && exp_q.size() > 0; k++) @(negedge clk);
        chk(exp_q.size() == 0, "R8 periods drained", exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        bit ma[16], wa[16], mb[16], wb[16];
        ma = '{0,1,1,0,0,1,0,1,1,0,0,0,0,0,0,0};
        wa = '{0,0,1,0,1,0,0,1,0,0,0,0,0,0,0,0};
        mb = '{0,1,0,1,0,0,0,0,0,0,0,0,0,0,0,0};
        wb = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0};

        rst = 1'b1; mode_sel = 1'b1;
        repeat (3) @(negedge clk);
        chk(pulse == 1'b0, "R3 reset low", pulse, 0);
        rst = 1'b0; mon_en = 1;
        @(negedge clk);
        chk(pulse == 1'b1, "R4 first cycle high", pulse, 1);
        run_seq(10, ma, wa);

        // reset during a high phase, select held at 1
        mode_sel = 1'b1;
        rst = 1'b1; mon_en = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(pulse == 1'b0, "R3 mid-period reset low", pulse, 0);
        end
        exp_q.delete();
        rst = 1'b0; mon_en = 1;
        @(negedge clk);
        chk(pulse == 1'b1, "R4 restart high", pulse, 1);
        run_seq(4, mb, wb);
        mon_en = 0;

        summary();
        $finish;
    end
endmodule